// File: doc/BRIEF.md
# Transactional Memory Conflict Tracker

This block gives a small direct-mapped private cache best-effort transactional memory. The core opens a transaction with a command and then issues ordinary loads and stores. Every line has two tracking bits. One marks lines the transaction has read and the other marks lines it has written. A snoop port from other cores checks each remote invalidation or remote read against these bits. A clash fails the transaction. From then on, core accesses become no-ops and each response is flagged with a two-bit reason code.

Commit and abort act on all lines at once in a single cycle. Commit makes the written lines normal dirty lines. Abort drops them. Speculative data never leaves the block. A snoop that reads a speculatively written line gets a miss and is served by the next level. Before a transaction first overwrites a dirty line, the block writes the old value back, so the next level holds the value from before the transaction.

Top module: `tmt_tracker`

## Requirements
- R1: Outside a transaction, a load hit returns the line data. A load miss allocates the line clean, holding `req_fill_data`, and returns that value. A store writes `req_wdata` and marks the line dirty, allocating it on a miss. Every request gets `rsp_valid` on the next cycle, and `rsp_txfail` stays 0.
- R2: When a miss replaces a valid dirty line, `wb_valid` pulses on the next cycle with that line's full address and data.
- R3: Requests are encoded as follows. `req_we`=1 is a store. With `req_we`=0, `req_txcmd` 00 is a load, 01 is begin, 10 is commit and 11 is abort. A command is acknowledged with `rsp_valid` on the next cycle, with `rsp_hit`=0 and `rsp_data`=0. Commit or abort outside a transaction has no effect.
- R4: Inside a transaction, a load adds its line to the read set and a store adds its line to the write set.
- R5: Inside a transaction, a snoop invalidation that hits a line in either set fails the transaction with reason 01. Any snoop invalidation that hits removes the line. Outside a transaction, no failure is recorded.
- R6: A snoop read that hits a write-set line answers with `snp_rsp_hit`=0 and data 0. Inside a transaction, it also fails the transaction with reason 10. A snoop read of any other valid line returns its data.
- R7: Once a transaction has failed, loads and stores change no state. They respond with `rsp_hit`=0, `rsp_data`=0, `rsp_txfail`=1 and the reason recorded by the first failure.
- R8: Suppose a transactional miss would replace a valid line that is in either set. Then the transaction fails with reason 11, the line is kept and no writeback occurs.
- R9: Abort drops every write-set line, clears both sets and the failure, and ends the transaction.
- R10: Commit of a transaction that has not failed keeps write-set lines valid and dirty, so a snoop read sees them. It then clears the sets and ends the transaction. Commit of a failed transaction acts as an abort, and its acknowledgement carries `rsp_txfail`=1 and the reason.
- R11: A transactional store that hits a dirty line not yet in the write set first writes the old value back, with `wb_valid` on the next cycle.
- R12: If a snoop conflict and a core load or store occur in the same cycle, the core access is treated as failed: it becomes a no-op and its response is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_we | input | 1 | 1 = store |
| req_txcmd | input | 2 | Load subtype: 00 load, 01 begin, 10 commit, 11 abort |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_fill_data | input | DATA_W | Next-level data for a load miss |
| rsp_valid | output | 1 | Response or acknowledgement |
| rsp_hit | output | 1 | Access hit in the cache |
| rsp_data | output | DATA_W | Load data |
| rsp_txfail | output | 1 | Transaction failed |
| rsp_reason | output | 2 | 01 invalidation, 10 remote read, 11 capacity |
| snp_valid | input | 1 | Snoop present |
| snp_inv | input | 1 | 1 = invalidation, 0 = remote read |
| snp_addr | input | ADDR_W | Snoop word address |
| snp_rsp_valid | output | 1 | Snoop answer |
| snp_rsp_hit | output | 1 | Non-speculative hit |
| snp_rsp_data | output | DATA_W | Data for a non-speculative hit |
| wb_valid | output | 1 | Writeback pulse |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |

## Verification
The bench builds the block with four lines, an 8-bit address and 16-bit data. With so few lines, a second address shares an index after a few accesses, so victim writebacks and capacity failures occur within short sequences. The small widths keep the table rows readable. Commit, abort and failed commit are driven against lines that sit in only the read set, only the write set, or neither. One directed case drives a conflicting snoop in the same cycle as a core access.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

    typedef enum logic [1:0] {
        TXC_NONE   = 2'b00,
        TXC_BEGIN  = 2'b01,
        TXC_COMMIT = 2'b10,
        TXC_ABORT  = 2'b11
    } txcmd_e;

    typedef enum logic [1:0] {
        FR_NONE  = 2'b00,
        FR_INVAL = 2'b01,
        FR_RREAD = 2'b10,
        FR_CAP   = 2'b11
    } fail_reason_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic rd;
        logic wr;
    } line_meta_t;

    function automatic line_meta_t meta_clear();
        line_meta_t m;
        m = '0;
        return m;
    endfunction

    function automatic logic meta_in_sets(line_meta_t m);
        return m.valid && (m.rd || m.wr);
    endfunction

endpackage

// File: rtl/tmt_line_array.sv
module tmt_line_array
    import tmt_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  c_idx,
    output line_meta_t        c_meta,
    output logic [TAG_W-1:0]  c_tag,
    output logic [DATA_W-1:0] c_data,
    input  logic [IDX_W-1:0]  s_idx,
    output line_meta_t        s_meta,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  line_meta_t        wr_meta,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              commit_all,
    input  logic              abort_all
);

    line_meta_t        meta_q [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  rd_vec;
    logic [LINES-1:0]  wr_vec;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= meta_clear();
            end else begin
                if (commit_all) begin
                    meta_q[i].rd <= 1'b0;
                    meta_q[i].wr <= 1'b0;
                end
                if (abort_all) begin
                    if (meta_q[i].wr) begin
                        meta_q[i].valid <= 1'b0;
                        meta_q[i].dirty <= 1'b0;
                    end
                    meta_q[i].rd <= 1'b0;
                    meta_q[i].wr <= 1'b0;
                end
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    meta_q[i] <= wr_meta;
                end
                if (inv_en && inv_idx == IDX_W'(i)) begin
                    meta_q[i] <= meta_clear();
                end
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end

        assign rd_vec[i] = meta_q[i].rd;
        assign wr_vec[i] = meta_q[i].wr;
    end

    assign c_meta = meta_q[c_idx];
    assign c_tag  = tag_q[c_idx];
    assign c_data = data_q[c_idx];
    assign s_meta = meta_q[s_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_data = data_q[s_idx];

    AST_COMMIT_CLEARS_SETS: assert property (@(posedge clk) disable iff (rst)
        commit_all |=> (rd_vec == '0 && wr_vec == '0)); // R10
    AST_ABORT_CLEARS_SETS: assert property (@(posedge clk) disable iff (rst)
        abort_all |=> (rd_vec == '0 && wr_vec == '0)); // R9

endmodule

// File: rtl/tmt_snoop_eval.sv
module tmt_snoop_eval
    import tmt_pkg::*;
#(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic              snp_inv,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              tx_active,
    input  line_meta_t        meta,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              hit,
    output logic              conflict,
    output fail_reason_e      reason,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);

    always_comb begin
        hit      = snp_valid && meta.valid && (line_tag == snp_tag);
        conflict = 1'b0;
        reason   = FR_NONE;
        if (hit && tx_active) begin
            if (snp_inv && (meta.rd || meta.wr)) begin
                conflict = 1'b1;
                reason   = FR_INVAL;
            end else if (!snp_inv && meta.wr) begin
                conflict = 1'b1;
                reason   = FR_RREAD;
            end
        end
        rsp_hit  = hit && !meta.wr;
        rsp_data = rsp_hit ? line_data : '0;
    end

endmodule

// File: rtl/tmt_tx_state.sv
module tmt_tx_state
    import tmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         begin_i,
    input  logic         end_i,
    input  logic         snp_conf_i,
    input  fail_reason_e snp_reason_i,
    input  logic         cap_conf_i,
    output logic         tx_active,
    output logic         failed,
    output fail_reason_e reason
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_active <= 1'b0;
            failed    <= 1'b0;
            reason    <= FR_NONE;
        end else if (tx_active && end_i) begin
            tx_active <= 1'b0;
            failed    <= 1'b0;
            reason    <= FR_NONE;
        end else if (!tx_active && begin_i) begin
            tx_active <= 1'b1;
            failed    <= 1'b0;
            reason    <= FR_NONE;
        end else if (tx_active && !failed && (snp_conf_i || cap_conf_i)) begin
            failed <= 1'b1;
            reason <= snp_conf_i ? snp_reason_i : FR_CAP;
        end
    end

    AST_END_LEAVES_TX: assert property (@(posedge clk) disable iff (rst)
        (tx_active && end_i) |=> (!tx_active && !failed)); // R9
    AST_REASON_HELD: assert property (@(posedge clk) disable iff (rst)
        (failed && !end_i) |=> (failed && reason == $past(reason))); // R7

endmodule

// File: rtl/tmt_tracker.sv
module tmt_tracker
    import tmt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_txcmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_txfail,
    output logic [1:0]        rsp_reason,
    input  logic              snp_valid,
    input  logic              snp_inv,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_rsp_valid,
    output logic              snp_rsp_hit,
    output logic [DATA_W-1:0] snp_rsp_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_req_tag, s_req_tag;
    line_meta_t        c_meta, s_meta, new_meta;
    logic [TAG_W-1:0]  c_tag, s_tag;
    logic [DATA_W-1:0] c_data, s_data, new_data;
    txcmd_e            cmd;
    logic              c_hit, is_access, cmd_begin, cmd_commit, cmd_abort;
    logic              tx_active, failed, fail_eff, suppress, cap_conf, do_access;
    logic              core_we, commit_bad, commit_all, abort_all, wb_now;
    fail_reason_e      reason_q, s_reason, cur_reason;
    logic              s_hit, s_conf, s_rsp_hit;
    logic [DATA_W-1:0] s_rsp_data;

    assign c_idx     = req_addr[IDX_W-1:0];
    assign c_req_tag = req_addr[ADDR_W-1:IDX_W];
    assign s_idx     = snp_addr[IDX_W-1:0];
    assign s_req_tag = snp_addr[ADDR_W-1:IDX_W];
    assign cmd       = txcmd_e'(req_txcmd);

    tmt_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst(rst),
        .c_idx(c_idx), .c_meta(c_meta), .c_tag(c_tag), .c_data(c_data),
        .s_idx(s_idx), .s_meta(s_meta), .s_tag(s_tag), .s_data(s_data),
        .wr_en(core_we), .wr_idx(c_idx), .wr_tag(c_req_tag), .wr_data(new_data),
        .wr_meta(new_meta),
        .inv_en(snp_inv && s_hit), .inv_idx(s_idx),
        .commit_all(commit_all), .abort_all(abort_all)
    );

    tmt_snoop_eval #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_tag(s_req_tag),
        .tx_active(tx_active), .meta(s_meta), .line_tag(s_tag), .line_data(s_data),
        .hit(s_hit), .conflict(s_conf), .reason(s_reason),
        .rsp_hit(s_rsp_hit), .rsp_data(s_rsp_data)
    );

    tmt_tx_state u_tx (
        .clk(clk), .rst(rst),
        .begin_i(cmd_begin), .end_i(cmd_commit || cmd_abort),
        .snp_conf_i(s_conf), .snp_reason_i(s_reason), .cap_conf_i(cap_conf),
        .tx_active(tx_active), .failed(failed), .reason(reason_q)
    );

    always_comb begin
        is_access  = req_valid && (req_we || cmd == TXC_NONE);
        cmd_begin  = req_valid && !req_we && cmd == TXC_BEGIN;
        cmd_commit = req_valid && !req_we && cmd == TXC_COMMIT;
        cmd_abort  = req_valid && !req_we && cmd == TXC_ABORT;
        c_hit      = c_meta.valid && (c_tag == c_req_tag);
        fail_eff   = tx_active && (failed || s_conf);
        cur_reason = failed ? reason_q : s_reason;
        suppress   = is_access && fail_eff;
        cap_conf   = is_access && tx_active && !fail_eff && !c_hit && meta_in_sets(c_meta);
        do_access  = is_access && !fail_eff && !cap_conf;
        core_we    = do_access && (req_we || !c_hit || tx_active);
        commit_bad = cmd_commit && tx_active && fail_eff;
        commit_all = cmd_commit && tx_active && !fail_eff;
        abort_all  = (cmd_abort && tx_active) || commit_bad;

        new_meta.valid = 1'b1;
        new_meta.dirty = req_we || (c_hit && c_meta.dirty);
        new_meta.rd    = (tx_active && !req_we) || (c_hit && c_meta.rd);
        new_meta.wr    = (tx_active && req_we) || (c_hit && c_meta.wr);
        if (req_we)     new_data = req_wdata;
        else if (c_hit) new_data = c_data;
        else            new_data = req_fill_data;

        wb_now = do_access &&
                 ((!c_hit && c_meta.valid && c_meta.dirty) ||
                  (c_hit && req_we && tx_active && c_meta.dirty && !c_meta.wr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_data      <= '0;
            rsp_txfail    <= 1'b0;
            rsp_reason    <= FR_NONE;
            snp_rsp_valid <= 1'b0;
            snp_rsp_hit   <= 1'b0;
            snp_rsp_data  <= '0;
            wb_valid      <= 1'b0;
            wb_addr       <= '0;
            wb_data       <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= do_access && c_hit;
            rsp_data   <= (do_access && !req_we) ? new_data : '0;
            rsp_txfail <= suppress || cap_conf || commit_bad;
            if (suppress || commit_bad) rsp_reason <= cur_reason;
            else if (cap_conf)          rsp_reason <= FR_CAP;
            else                        rsp_reason <= FR_NONE;
            snp_rsp_valid <= snp_valid;
            snp_rsp_hit   <= s_rsp_hit;
            snp_rsp_data  <= s_rsp_data;
            wb_valid      <= wb_now;
            wb_addr       <= {c_tag, c_idx};
            wb_data       <= c_data;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_FAIL_OUTSIDE_TX: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tx_active) |=> !rsp_txfail); // R5
    AST_NO_SPEC_TO_SNOOP: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_inv && s_meta.wr) |=> !snp_rsp_hit); // R6
    AST_CAP_KEEPS_LINE: assert property (@(posedge clk) disable iff (rst)
        cap_conf |=> (!wb_valid && rsp_txfail)); // R8

endmodule

// File: tb/tmt_tracker_tb.sv
`timescale 1ns/1ps
module tmt_tracker_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;

    localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_BEG = 3'd2, OP_CMT = 3'd3,
                           OP_ABT = 3'd4, OP_SINV = 3'd5, OP_SRD = 3'd6;

    typedef struct packed {
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          e_hit;
        logic [DW-1:0] e_data;
        logic          e_fail;
        logic [1:0]    e_reason;
        logic          e_wb;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{OP_ST,  8'h05, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd1},  // R1 store miss
        '{OP_LD,  8'h05, 16'h0000, 1'b1, 16'hAAAA, 1'b0, 2'd0, 1'b0, 4'd1},  // R1 load hit
        '{OP_LD,  8'h09, 16'h1111, 1'b0, 16'h1111, 1'b0, 2'd0, 1'b1, 4'd2},  // R2 dirty victim
        '{OP_SRD, 8'h09, 16'h0000, 1'b1, 16'h1111, 1'b0, 2'd0, 1'b0, 4'd6},  // R6 plain snoop read
        '{OP_BEG, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd3},  // R3 begin ack
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h1111, 1'b0, 2'd0, 1'b0, 4'd4},  // R4 read set
        '{OP_ST,  8'h02, 16'hBEEF, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd4},  // R4 write set
        '{OP_SRD, 8'h02, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd6},  // R6 hidden
        '{OP_LD,  8'h09, 16'h0000, 1'b0, 16'h0000, 1'b1, 2'd2, 1'b0, 4'd7},  // R7 no-op
        '{OP_ABT, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 abort
        '{OP_LD,  8'h02, 16'h2222, 1'b0, 16'h2222, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 line dropped
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h1111, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 read line kept
        '{OP_BEG, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
        '{OP_ST,  8'h09, 16'h3333, 1'b1, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd11}, // R11 clean, no wb
        '{OP_ST,  8'h03, 16'h4444, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
        '{OP_CMT, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 commit
        '{OP_SRD, 8'h03, 16'h0000, 1'b1, 16'h4444, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 visible
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 kept
        '{OP_BEG, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
        '{OP_LD,  8'h03, 16'h0000, 1'b1, 16'h4444, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
        '{OP_SINV,8'h03, 16'h0000, 1'b1, 16'h4444, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 inv conflict
        '{OP_ST,  8'h09, 16'h5555, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b0, 4'd5},  // R5 reason 01
        '{OP_CMT, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b0, 4'd10}, // R10 failed commit
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd7},  // R7 store was no-op
        '{OP_BEG, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
        '{OP_LD,  8'h0D, 16'h6666, 1'b0, 16'h0000, 1'b1, 2'd3, 1'b0, 4'd8},  // R8 capacity
        '{OP_ABT, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd9},  // R9
        '{OP_LD,  8'h09, 16'h0000, 1'b1, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd8},  // R8 not evicted
        '{OP_BEG, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
        '{OP_ST,  8'h09, 16'h7777, 1'b1, 16'h0000, 1'b0, 2'd0, 1'b1, 4'd11}, // R11 old value out
        '{OP_ABT, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd9},  // R9
        '{OP_LD,  8'h09, 16'h3333, 1'b0, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 dropped
        '{OP_SINV,8'h09, 16'h0000, 1'b1, 16'h3333, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 plain inv
        '{OP_LD,  8'h05, 16'h0ABC, 1'b0, 16'h0ABC, 1'b0, 2'd0, 1'b0, 4'd5}   // R5 no fail outside
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_we, snp_valid, snp_inv;
    logic [1:0]    req_txcmd;
    logic [AW-1:0] req_addr, snp_addr, wb_addr;
    logic [DW-1:0] req_wdata, req_fill_data, rsp_data, snp_rsp_data, wb_data;
    logic          rsp_valid, rsp_hit, rsp_txfail, snp_rsp_valid, snp_rsp_hit, wb_valid;
    logic [1:0]    rsp_reason;
    int            n_tests = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    tmt_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_we(req_we), .req_txcmd(req_txcmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_fill_data(req_fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_txfail(rsp_txfail), .rsp_reason(rsp_reason),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
        .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit), .snp_rsp_data(snp_rsp_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_we = 1'b0; req_txcmd = 2'b00;
        req_addr = '0; req_wdata = '0; req_fill_data = '0;
        snp_valid = 1'b0; snp_inv = 1'b0; snp_addr = '0;
    endtask

    task automatic drive(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_inputs();
        case (op)
            OP_LD:   begin req_valid = 1'b1; req_addr = a; req_fill_data = d; end
            OP_ST:   begin req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; end
            OP_BEG:  begin req_valid = 1'b1; req_txcmd = 2'b01; end
            OP_CMT:  begin req_valid = 1'b1; req_txcmd = 2'b10; end
            OP_ABT:  begin req_valid = 1'b1; req_txcmd = 2'b11; end
            OP_SINV: begin snp_valid = 1'b1; snp_inv = 1'b1; snp_addr = a; end
            default: begin snp_valid = 1'b1; snp_addr = a; end
        endcase
    endtask

    task automatic run_vec(input vec_t v, input int k);
        string tag;
        @(negedge clk);
        drive(v.op, v.addr, v.data);
        @(negedge clk);
        idle_inputs();
        tag = $sformatf("R%0d row %0d", v.req, k);
        if (v.op == OP_SINV || v.op == OP_SRD) begin
            chk(snp_rsp_valid == 1'b1, {tag, " snp valid"}, snp_rsp_valid, 1);
            chk(snp_rsp_hit == v.e_hit, {tag, " snp hit"}, snp_rsp_hit, v.e_hit);
            chk(snp_rsp_data == v.e_data, {tag, " snp data"}, snp_rsp_data, v.e_data);
        end else begin
            chk(rsp_valid == 1'b1, {tag, " rsp valid"}, rsp_valid, 1);
            chk(rsp_hit == v.e_hit, {tag, " hit"}, rsp_hit, v.e_hit);
            chk(rsp_data == v.e_data, {tag, " data"}, rsp_data, v.e_data);
            chk(rsp_txfail == v.e_fail, {tag, " txfail"}, rsp_txfail, v.e_fail);
            chk(rsp_reason == v.e_reason, {tag, " reason"}, rsp_reason, v.e_reason);
        end
        chk(wb_valid == v.e_wb, {tag, " wb"}, wb_valid, v.e_wb);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rsp_valid == 1'b0 && snp_rsp_valid == 1'b0 && wb_valid == 1'b0,
            "R1 reset outputs", {rsp_valid, snp_rsp_valid, wb_valid}, 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R2 writeback address and data of a dirty victim
        @(negedge clk); drive(OP_ST, 8'h10, 16'h1234);
        @(negedge clk); drive(OP_LD, 8'h14, 16'h0055);
        @(negedge clk); idle_inputs();
        chk(wb_valid == 1'b1, "R2 wb pulse", wb_valid, 1);
        chk(wb_addr == 8'h10, "R2 wb addr", wb_addr, 8'h10);
        chk(wb_data == 16'h1234, "R2 wb data", wb_data, 16'h1234);

        // R12 snoop conflict in the same cycle as a core load
        @(negedge clk); drive(OP_BEG, 8'h00, 16'h0);
        @(negedge clk); drive(OP_ST, 8'h21, 16'h0001);
        @(negedge clk);
        drive(OP_SRD, 8'h21, 16'h0);
        req_valid = 1'b1; req_addr = 8'h22; req_fill_data = 16'h0999;
        @(negedge clk); idle_inputs();
        chk(rsp_txfail == 1'b1, "R12 same-cycle fail", rsp_txfail, 1);
        chk(rsp_reason == 2'd2, "R12 same-cycle reason", rsp_reason, 2);
        chk(rsp_hit == 1'b0 && rsp_data == '0, "R12 no-op", rsp_data, 0);
        chk(snp_rsp_hit == 1'b0, "R6 speculative hidden", snp_rsp_hit, 0);
        @(negedge clk); drive(OP_ABT, 8'h00, 16'h0);
        @(negedge clk); idle_inputs();
        // R12 the suppressed load left line 2 untouched
        @(negedge clk); drive(OP_SRD, 8'h02, 16'h0);
        @(negedge clk); idle_inputs();
        chk(snp_rsp_hit == 1'b1 && snp_rsp_data == 16'h2222, "R12 line 2 intact",
            snp_rsp_data, 16'h2222);

        // R3 commit outside a transaction: plain ack
        @(negedge clk); drive(OP_CMT, 8'h00, 16'h0);
        @(negedge clk); idle_inputs();
        chk(rsp_valid == 1'b1 && rsp_txfail == 1'b0, "R3 idle commit ack", rsp_txfail, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule